// File: doc/BRIEF.md
# Match-Driven Multi-Channel PWM Timer

This block is a free-running timer whose counter advances once per programmable number of clock cycles. Four compare values are checked against the counter. When a compare value equals the counter, the block can wrap the counter to zero, halt it, or latch a pending interrupt flag. The same compare events set and clear a small group of pulse-width outputs. Each output takes its rising edge either from the period compare or from the compare just below its own index. Its falling edge always comes from its own compare.

Software drives the block through a single-cycle register port: an address, a write strobe and write data, with read data returned combinationally. A typical setup holds the counter at zero, loads the prescale, period and duty values, and selects the wrap-on-period action. It then enables counting. The outputs run without further attention. Pending flags are cleared by writing ones to them.

Top module: `pwm_tmr`

## Requirements
- R1: The prescale counter (address 4) advances by one on every clock cycle in which the timer is running. On a cycle where it is greater than or equal to the prescale limit (address 3), that cycle is a tick: the prescale counter returns to 0 and the timer counter (address 2) advances by one. The timer therefore advances once every limit+1 cycles.
- R2: The control register is at address 1. Bit 0 enables counting and bit 1 is a counter clear. While bit 1 is set, the timer and prescale counters are held at zero and no tick occurs.
- R3: Compare k (addresses 8 to 11) matches only on a tick at which the timer counter equals its value. If the wrap bit of compare k is set, the counter becomes 0 at that tick instead of advancing. A period compare of P therefore gives a period of P+1 ticks.
- R4: If the stop bit of a matching compare is set, the timer counter keeps its value at that tick. The prescale counter returns to 0, and enable bit 0 of the control register is cleared.
- R5: The action register is at address 5. It holds three bits per compare k: bit 3k raises the pending flag, bit 3k+1 wraps the counter, and bit 3k+2 stops it.
- R6: Single-edge mode is mode bit n-1 = 0 in the mode register (address 6). In this mode, output n (pwm_out bit n-1) is set by compare 0 and cleared by compare n. It stays high for (compare n + 1)·(limit+1) cycles and low for (compare 0 − compare n)·(limit+1) cycles.
- R7: Double-edge mode is mode bit n-1 = 1. For outputs n ≥ 2 in this mode, the output is set by compare n-1 and cleared by compare n, so it stays high for (compare n − compare n-1)·(limit+1) cycles. Output 1 always behaves as single-edge.
- R8: When an output receives a set event and a clear event at the same tick, it goes low.
- R9: The pending register is at address 0, with bit k for compare k. A bit is set by a match whose raise bit is set. It is cleared by writing 1 to it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R10: The timer counter, prescale counter, prescale limit, action, mode and compare registers read back the value written.
- R11: After reset every register reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 3 | Pulse-width outputs 1 to 3 (bit 0 is output 1) |

## Verification
The assertions assume the prescale counter only runs past the limit when software writes a value above it. They also assume that no counter write coincides with a compare action, because a bus write to a counter overrides the tick for that cycle. The stimulus follows these assumptions. It changes counters, limits and compare values only while the counter is held by the clear bit or stopped. Every compare set it programs is ordered below the period value, so each output has non-zero high and low phases, except in the deliberate same-tick collision case.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_PEND  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_TCNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PSCL  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PCNT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ACT   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CBASE = 4'd8;

  localparam int CB_EN  = 0;
  localparam int CB_CLR = 1;

  localparam int AF_IRQ  = 0;
  localparam int AF_WRAP = 1;
  localparam int AF_STOP = 2;
  localparam int AF_W    = 3;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int NUM_M  = 4,
  parameter int NUM_CH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [W-1:0]              bus_wdata,
  output logic [W-1:0]              bus_rdata,
  input  logic [W-1:0]              tc,
  input  logic [W-1:0]              pc,
  input  logic                      stop_hit,
  input  logic [NUM_M-1:0]          irq_set,
  output logic                      en,
  output logic                      crst,
  output logic [W-1:0]              pr,
  output logic [AF_W*NUM_M-1:0]     act,
  output logic [NUM_CH-1:0]         mode,
  output logic [NUM_M-1:0][W-1:0]   cmp,
  output logic                      tc_wr,
  output logic                      pc_wr
);
  localparam int ACT_W = AF_W * NUM_M;

  logic                    en_q, en_d;
  logic                    clr_q, clr_d;
  logic [W-1:0]            pr_q, pr_d;
  logic [ACT_W-1:0]        act_q, act_d;
  logic [NUM_CH-1:0]       mode_q, mode_d;
  logic [NUM_M-1:0][W-1:0] cmp_q, cmp_d;
  logic [NUM_M-1:0]        pend_q, pend_d;
  logic [NUM_M-1:0]        w1c;

  assign tc_wr = bus_we && (bus_addr == A_TCNT);
  assign pc_wr = bus_we && (bus_addr == A_PCNT);
  assign w1c   = (bus_we && (bus_addr == A_PEND)) ? bus_wdata[NUM_M-1:0] : '0;

  always_comb begin
    en_d   = en_q;
    clr_d  = clr_q;
    pr_d   = pr_q;
    act_d  = act_q;
    mode_d = mode_q;
    cmp_d  = cmp_q;
    if (bus_we) begin
      case (bus_addr)
        A_CTRL: begin
          en_d  = bus_wdata[CB_EN];
          clr_d = bus_wdata[CB_CLR];
        end
        A_PSCL:  pr_d   = bus_wdata;
        A_ACT:   act_d  = bus_wdata[ACT_W-1:0];
        A_MODE:  mode_d = bus_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
    for (int k = 0; k < NUM_M; k++) begin
      if (bus_we && (bus_addr == A_CBASE + ADDR_W'(k))) cmp_d[k] = bus_wdata;
    end
    if (stop_hit) en_d = 1'b0;
    pend_d = (pend_q & ~w1c) | irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
      pr_q   <= '0;
      act_q  <= '0;
      mode_q <= '0;
      cmp_q  <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      clr_q  <= clr_d;
      pr_q   <= pr_d;
      act_q  <= act_d;
      mode_q <= mode_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PEND: bus_rdata[NUM_M-1:0] = pend_q;
      A_CTRL: begin
        bus_rdata[CB_EN]  = en_q;
        bus_rdata[CB_CLR] = clr_q;
      end
      A_TCNT:  bus_rdata = tc;
      A_PSCL:  bus_rdata = pr_q;
      A_PCNT:  bus_rdata = pc;
      A_ACT:   bus_rdata[ACT_W-1:0] = act_q;
      A_MODE:  bus_rdata[NUM_CH-1:0] = mode_q;
      default: ;
    endcase
    for (int k = 0; k < NUM_M; k++) begin
      if (bus_addr == A_CBASE + ADDR_W'(k)) bus_rdata = cmp_q[k];
    end
  end

  assign en   = en_q;
  assign crst = clr_q;
  assign pr   = pr_q;
  assign act  = act_q;
  assign mode = mode_q;
  assign cmp  = cmp_q;

  // R4: a stop action leaves the enable bit low
  a_r4_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !en_q);

  for (genvar k = 0; k < NUM_M; k++) begin : g_pend_chk
    a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[k] |=> pend_q[k]);
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[k] && !irq_set[k]) |=> !pend_q[k]);
  end
endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         crst,
  input  logic [W-1:0] pr,
  input  logic         tc_wr,
  input  logic         pc_wr,
  input  logic [W-1:0] wdata,
  input  logic         wrap_hit,
  input  logic         stop_hit,
  output logic         tick,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc
);
  logic         run;
  logic [W-1:0] tc_q, tc_d;
  logic [W-1:0] pc_q, pc_d;

  assign run  = en && !crst;
  assign tick = run && (pc_q >= pr);

  always_comb begin
    tc_d = tc_q;
    pc_d = pc_q;
    if (run) pc_d = tick ? '0 : pc_q + W'(1);
    if (tick) begin
      if (wrap_hit)       tc_d = '0;
      else if (!stop_hit) tc_d = tc_q + W'(1);
    end
    if (pc_wr) pc_d = wdata;
    if (tc_wr) tc_d = wdata;
    if (crst) begin
      tc_d = '0;
      pc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      tc_q <= tc_d;
      pc_q <= pc_d;
    end
  end

  assign tc = tc_q;
  assign pc = pc_q;

  a_r2_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    crst |=> (tc_q == '0 && pc_q == '0));
  a_r1_tc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_hit && !stop_hit && !tc_wr) |=> tc_q == $past(tc_q) + W'(1));
  a_r1_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !pc_wr) |=> pc_q == $past(pc_q) + W'(1));
  a_r3_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hit && !tc_wr && !crst) |=> tc_q == '0);
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !wrap_hit && !tc_wr && !crst) |=> tc_q == $past(tc_q));
endmodule

// File: rtl/pwm_tmr_match.sv
module pwm_tmr_match
  import pwm_tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int NUM_M  = 4,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [W-1:0]            tc,
  input  logic [NUM_M-1:0][W-1:0] cmp,
  input  logic [AF_W*NUM_M-1:0]   act,
  input  logic [NUM_CH-1:0]       mode,
  output logic                    wrap_hit,
  output logic                    stop_hit,
  output logic [NUM_M-1:0]        irq_set,
  output logic [NUM_CH-1:0]       pwm_out
);
  logic [NUM_M-1:0]  hit;
  logic [NUM_M-1:0]  wrap_v, stop_v;
  logic [NUM_CH-1:0] set_ev, clr_ev;
  logic [NUM_CH-1:0] out_q, out_d;

  for (genvar k = 0; k < NUM_M; k++) begin : g_cmp
    assign hit[k]     = tick && (tc == cmp[k]);
    assign irq_set[k] = hit[k] && act[AF_W*k + AF_IRQ];
    assign wrap_v[k]  = hit[k] && act[AF_W*k + AF_WRAP];
    assign stop_v[k]  = hit[k] && act[AF_W*k + AF_STOP];
  end

  assign wrap_hit = |wrap_v;
  assign stop_hit = |stop_v;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    assign clr_ev[n] = hit[n+1];
    if (n == 0) begin : g_first
      assign set_ev[n] = hit[0];
    end else begin : g_rest
      assign set_ev[n] = mode[n] ? hit[n] : hit[0];
    end
  end

  always_comb begin
    out_d = out_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (clr_ev[n])      out_d[n] = 1'b0;
      else if (set_ev[n]) out_d[n] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_out_chk
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n+1] |=> !out_q[n]);
    if (n == 0) begin : g_one
      a_r6_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && !hit[1]) |=> out_q[0]);
    end else begin : g_more
      a_r6_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[n] && hit[0] && !hit[n+1]) |=> out_q[n]);
      a_r7_double_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[n] && hit[n] && !hit[n+1]) |=> out_q[n]);
    end
  end
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
  import pwm_tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int NUM_M = NUM_CH + 1;

  logic [1:0]              rs_q;
  logic                    rst_s_n;
  logic                    en, crst, tick, tc_wr, pc_wr;
  logic                    wrap_hit, stop_hit;
  logic [W-1:0]            pr, tc, pc;
  logic [AF_W*NUM_M-1:0]   act;
  logic [NUM_CH-1:0]       mode;
  logic [NUM_M-1:0][W-1:0] cmp;
  logic [NUM_M-1:0]        irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pwm_tmr_regs #(.W(W), .NUM_M(NUM_M), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tc(tc), .pc(pc), .stop_hit(stop_hit), .irq_set(irq_set),
    .en(en), .crst(crst), .pr(pr), .act(act), .mode(mode), .cmp(cmp),
    .tc_wr(tc_wr), .pc_wr(pc_wr)
  );

  pwm_tmr_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_s_n), .en(en), .crst(crst), .pr(pr),
    .tc_wr(tc_wr), .pc_wr(pc_wr), .wdata(bus_wdata),
    .wrap_hit(wrap_hit), .stop_hit(stop_hit),
    .tick(tick), .tc(tc), .pc(pc)
  );

  pwm_tmr_match #(.W(W), .NUM_M(NUM_M), .NUM_CH(NUM_CH)) u_match (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .tc(tc), .cmp(cmp),
    .act(act), .mode(mode),
    .wrap_hit(wrap_hit), .stop_hit(stop_hit), .irq_set(irq_set),
    .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm_tmr_bench.sv
module pwm_tmr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  pwm_out;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm_tmr u_pwm_tmr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    bus_addr = a; bus_we = 1'b0;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int guard = 0;
    logic prev;
    @(negedge clk); prev = pwm_out[ch];
    while (!(prev == 1'b0 && pwm_out[ch] == 1'b1) && guard < 2000) begin
      prev = pwm_out[ch]; @(negedge clk); guard++;
    end
    hi = 0; lo = 0;
    while (pwm_out[ch] == 1'b1 && guard < 2000) begin hi++; @(negedge clk); guard++; end
    while (pwm_out[ch] == 1'b0 && guard < 2000) begin lo++; @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, hi, lo;
    int cm [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state of every register and output
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk("R11 reset register", v, 0);
    end
    chk("R11 outputs low", int'(pwm_out), 0);

    // R10: read-back while stopped
    wr(4'd2, 123); rd(4'd2, v); chk("R10 timer counter", v, 123);
    wr(4'd4, 7);   rd(4'd4, v); chk("R10 prescale counter", v, 7);
    wr(4'd3, 85);  rd(4'd3, v); chk("R10 prescale limit", v, 85);
    wr(4'd5, 12'hA5B); rd(4'd5, v); chk("R10 action", v, 12'hA5B);
    wr(4'd6, 5);   rd(4'd6, v); chk("R10 mode", v, 5);
    wr(4'd10, 999); rd(4'd10, v); chk("R10 compare 2", v, 999);
    wr(4'd5, 0); wr(4'd6, 0);

    // R2: clear bit holds counters at zero even with enable set
    wr(4'd3, 0);
    wr(4'd1, 3);
    repeat (10) @(negedge clk);
    rd(4'd2, v); chk("R2 timer held", v, 0);
    rd(4'd4, v); chk("R2 prescale held", v, 0);

    // R1: prescale sweep
    for (int p = 0; p < 5; p++) begin
      for (int s = 0; s < 3; s++) begin
        int k;
        k = (s == 0) ? 1 : (s == 1) ? 5 : 13;
        wr(4'd1, 2);
        wr(4'd3, p);
        wr(4'd1, 1);
        repeat (k) @(negedge clk);
        rd(4'd2, v); chk("R1 timer count", v, k / (p + 1));
        rd(4'd4, v); chk("R1 prescale count", v, k % (p + 1));
      end
    end

    // R6 / R7 / R3 / R5: output timing sweep
    for (int set = 0; set < 2; set++) begin
      if (set == 0) begin cm[0] = 7; cm[1] = 2; cm[2] = 4; cm[3] = 6; end
      else          begin cm[0] = 9; cm[1] = 1; cm[2] = 5; cm[3] = 8; end
      for (int md = 0; md < 2; md++) begin
        for (int p = 0; p < 3; p++) begin
          int pl;
          pl = (p == 2) ? 3 : p;
          wr(4'd1, 2);
          wr(4'd3, pl);
          for (int k = 0; k < 4; k++) wr(4'(8 + k), cm[k]);
          wr(4'd5, 2);   // R5: wrap on compare 0 (bit 1)
          wr(4'd6, md ? 7 : 0);
          wr(4'd1, 1);
          for (int ch = 0; ch < 3; ch++) begin
            int eh, el;
            if (md == 1 && ch > 0) begin
              eh = (cm[ch+1] - cm[ch]) * (pl + 1);
              el = (cm[0] + 1) * (pl + 1) - eh;
              measure(ch, hi, lo);
              chk("R7 double-edge high", hi, eh);
              chk("R7 double-edge low", lo, el);
            end else begin
              eh = (cm[ch+1] + 1) * (pl + 1);
              el = (cm[0] - cm[ch+1]) * (pl + 1);
              measure(ch, hi, lo);
              chk("R6 single-edge high", hi, eh);
              chk("R3 R6 single-edge low", lo, el);
            end
          end
        end
      end
    end

    // R8: set and clear at the same tick keep the output low
    wr(4'd1, 2); wr(4'd3, 0);
    wr(4'd8, 7); wr(4'd9, 7); wr(4'd10, 3); wr(4'd11, 3);
    wr(4'd5, 2); wr(4'd6, 7);
    wr(4'd1, 1);
    repeat (20) @(negedge clk);
    begin
      int h1 = 0, h3 = 0;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (pwm_out[0]) h1++;
        if (pwm_out[2]) h3++;
      end
      chk("R8 single collision high cycles", h1, 0);
      chk("R8 double collision high cycles", h3, 0);
    end

    // R9: pending flags
    wr(4'd1, 2); wr(4'd3, 0);
    wr(4'd8, 9); wr(4'd9, 3);
    wr(4'd5, 2 | 8);  // wrap on compare 0, raise on compare 1 (bit 3)
    wr(4'd6, 0);
    wr(4'd1, 1);
    repeat (15) @(negedge clk);
    wr(4'd1, 0);
    rd(4'd0, v); chk("R9 flag pending", v, 2);
    wr(4'd0, 0); rd(4'd0, v); chk("R9 write zero keeps flag", v, 2);
    wr(4'd0, 2); rd(4'd0, v); chk("R9 write one clears flag", v, 0);

    // R4: stop on compare 0
    wr(4'd1, 2); wr(4'd3, 0); wr(4'd8, 5);
    wr(4'd5, 4);  // stop on compare 0 (bit 2)
    wr(4'd1, 1);
    repeat (20) @(negedge clk);
    rd(4'd2, v); chk("R4 timer holds at compare", v, 5);
    rd(4'd4, v); chk("R4 prescale at zero", v, 0);
    rd(4'd1, v); chk("R4 enable cleared", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule